// File: doc/BRIEF.md
# Ping-pong spike buffer controller

This block drives two external bit-mask memories for a spiking system that advances in time steps. One memory is the present buffer and one is the future buffer. A start pulse swaps their roles. The present buffer, which holds the events collected during the previous step, is then swept from row 0. The sweep reads each row, shows its mask to a downstream consumer, and writes the row back to zero once the consumer strobes advance. During the whole sweep, incoming event writes go straight to the future buffer.

A row holds `ROW_BITS` axon flags, and a flag of 1 means the axon spiked. Axon `a` sits in row `a >> 3`, at bit `a & 7`. The sweep length is the configured input count shifted right by 3. The memories have a fixed read latency. The controller keeps a leading read address `RD_LAT` rows ahead of a lagging clear address, so each row is consumed once and left empty for reuse.

Top module: `spike_pingpong_ctrl`

## Requirements
- R1: While reset is held and right after it, `ready_o` and `done_o` are 0, and neither memory sees a read or a write enable.
- R2: An event write (`ev_we_i`) is forwarded in the same cycle, with its row address and mask unchanged, to the write port of the future memory. It never reaches the present memory. It may fall in the same cycle as a clear of the same row index in the present memory.
- R3: After reset, memory 0 is present and memory 1 is future. A start pulse accepted in idle swaps the roles. A start pulse that arrives while a sweep is running is ignored and changes neither the roles nor the sweep.
- R4: On the three cycles after an accepted start (with a nonzero row count), the present memory gets reads of rows 0, 1 and 2 in that order, and no writes.
- R5: `ready_o` is 1 throughout the sweep phase. While it is 1, `mask_o` equals the stored content of the row at the lagging address, and the mask holds steady on cycles without advance.
- R6: An advance while ready writes zero to the lagging row of the present memory, reads row lagging+3 in the same cycle, and moves both addresses forward by one.
- R7: The number of rows swept is the input count shifted right by 3. An advance on the last row makes `done_o` go high for exactly one cycle on the next cycle, with `ready_o` low. Rows at or beyond that count keep their contents.
- R8: If the row count is 0, `done_o` pulses on the cycle after the accepted start, and the present memory sees no read and no write. The roles still swap.
- R9: Memory contract: the read pipeline of each memory is `RD_LAT` stages deep and advances only on cycles where its read enable is high. `mask_o` is taken from the present memory's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Step start pulse, swaps buffers when idle |
| advance_i | input | 1 | Consumer has taken the current mask |
| count_i | input | 17 | Configured number of inputs |
| ev_we_i | input | 1 | Event write strobe for the future buffer |
| ev_addr_i | input | 14 | Event row address |
| ev_mask_i | input | 8 | Event row mask |
| ready_o | output | 1 | Sweep phase active, mask valid |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| mask_o | output | 8 | Spike mask of the lagging row |
| m0_raddr | output | 14 | Memory 0 read address |
| m0_rden | output | 1 | Memory 0 read enable |
| m0_rdata | input | 8 | Memory 0 read data |
| m0_waddr | output | 14 | Memory 0 write address |
| m0_wdata | output | 8 | Memory 0 write data |
| m0_wren | output | 1 | Memory 0 write enable |
| m1_raddr | output | 14 | Memory 1 read address |
| m1_rden | output | 1 | Memory 1 read enable |
| m1_rdata | input | 8 | Memory 1 read data |
| m1_waddr | output | 14 | Memory 1 write address |
| m1_wdata | output | 8 | Memory 1 write data |
| m1_wren | output | 1 | Memory 1 write enable |

## Verification
The clear write behind the sweep and an incoming event write can fall in the same cycle, and both can target the same row index. The bench drives an event to row 1 in the very cycle that the advance clears row 1. It then checks that the two write ports carry the clear and the event at once. In a later step it checks that the row in the old future memory comes back with the event's mask while the swept row reads as zero. A start pulse is also driven in the middle of a sweep, and the next step's contents show whether a stray swap took place.

// File: rtl/spk_pkg.sv
package spk_pkg;
   typedef enum logic [2:0] {
      ST_RESET,
      ST_IDLE,
      ST_FILL,
      ST_SWEEP,
      ST_DONE
   } sweep_st_t;
endpackage

// File: rtl/spk_sweep_fsm.sv
module spk_sweep_fsm
   import spk_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int LIM_W  = 14,
   parameter int RD_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              advance_i,
   input  logic [LIM_W-1:0]  rows_i,
   output logic              ready_o,
   output logic              done_o,
   output logic              swap_o,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              clr_en_o,
   output logic [ADDR_W-1:0] clr_addr_o
);
   localparam logic [ADDR_W-1:0] FILL_LAST = ADDR_W'(RD_LAT - 1);
   localparam logic [ADDR_W-1:0] LAG       = ADDR_W'(RD_LAT);

   if (RD_LAT < 1) begin : g_bad_lat
      $error("spk_sweep_fsm: RD_LAT must be at least 1");
   end
   if (LIM_W > ADDR_W) begin : g_bad_lim
      $error("spk_sweep_fsm: row count wider than address");
   end

   sweep_st_t         st, st_nxt;
   logic [ADDR_W-1:0] lead_q, lag_q;
   logic              addr_clr, inc_lead, inc_lag;
   logic [ADDR_W:0]   rows_ext, lag_next_ext;
   logic              last_row;

   assign rows_ext     = (ADDR_W+1)'(rows_i);
   assign lag_next_ext = {1'b0, lag_q} + 1'b1;
   assign last_row     = (lag_next_ext == rows_ext);

   always_comb begin
      st_nxt   = st;
      addr_clr = 1'b0;
      inc_lead = 1'b0;
      inc_lag  = 1'b0;
      swap_o   = 1'b0;
      rd_en_o  = 1'b0;
      unique case (st)
         ST_RESET: begin
            addr_clr = 1'b1;
            st_nxt   = ST_IDLE;
         end
         ST_IDLE: begin
            if (start_i) begin
               addr_clr = 1'b1;
               swap_o   = 1'b1;
               st_nxt   = (rows_i == '0) ? ST_DONE : ST_FILL;
            end
         end
         ST_FILL: begin
            rd_en_o  = 1'b1;
            inc_lead = 1'b1;
            if (lead_q == FILL_LAST) st_nxt = ST_SWEEP;
         end
         ST_SWEEP: begin
            if (advance_i) begin
               rd_en_o  = 1'b1;
               inc_lead = 1'b1;
               inc_lag  = 1'b1;
               if (last_row) st_nxt = ST_DONE;
            end
         end
         ST_DONE:  st_nxt = ST_IDLE;
         default:  st_nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_RESET;
         lead_q <= '0;
         lag_q  <= '0;
      end else begin
         st <= st_nxt;
         if (addr_clr) begin
            lead_q <= '0;
            lag_q  <= '0;
         end else begin
            if (inc_lead) lead_q <= lead_q + 1'b1;
            if (inc_lag)  lag_q  <= lag_q + 1'b1;
         end
      end
   end

   assign ready_o    = (st == ST_SWEEP);
   assign done_o     = (st == ST_DONE);
   assign rd_addr_o  = lead_q;
   assign clr_en_o   = inc_lag;
   assign clr_addr_o = lag_q;

   AST_LAG_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (rd_addr_o == clr_addr_o + LAG)); // R6
   AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> ($past(st) == ST_FILL)); // R4
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_CLEAR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_o |-> ({1'b0, clr_addr_o} < rows_ext)); // R7
   AST_ZERO_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start_i && rows_i == '0) |=> (done_o && !rd_en_o && !clr_en_o)); // R8
endmodule

// File: rtl/spk_bank_route.sv
module spk_bank_route #(
   parameter int ADDR_W   = 14,
   parameter int ROW_BITS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           swap_i,
   input  logic                           rd_en_i,
   input  logic [ADDR_W-1:0]              rd_addr_i,
   input  logic                           clr_en_i,
   input  logic [ADDR_W-1:0]              clr_addr_i,
   input  logic                           ev_we_i,
   input  logic [ADDR_W-1:0]              ev_addr_i,
   input  logic [ROW_BITS-1:0]            ev_mask_i,
   input  logic [1:0][ROW_BITS-1:0]       bank_rdata_i,
   output logic [1:0][ADDR_W-1:0]         bank_raddr_o,
   output logic [1:0]                     bank_rden_o,
   output logic [1:0][ADDR_W-1:0]         bank_waddr_o,
   output logic [1:0][ROW_BITS-1:0]       bank_wdata_o,
   output logic [1:0]                     bank_wren_o,
   output logic [ROW_BITS-1:0]            mask_o
);
   if (ROW_BITS < 1) begin : g_bad_row
      $error("spk_bank_route: ROW_BITS must be positive");
   end

   logic pres_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pres_sel <= 1'b0;
      else if (swap_i) pres_sel <= ~pres_sel;
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic is_pres;
      assign is_pres         = (pres_sel == 1'(b));
      assign bank_raddr_o[b] = is_pres ? rd_addr_i : '0;
      assign bank_rden_o[b]  = is_pres & rd_en_i;
      assign bank_waddr_o[b] = is_pres ? clr_addr_i : ev_addr_i;
      assign bank_wdata_o[b] = is_pres ? '0 : ev_mask_i;
      assign bank_wren_o[b]  = is_pres ? clr_en_i : ev_we_i;

      AST_PRESENT_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_wren_o[b] && bank_rden_o[b]) |-> (bank_wdata_o[b] == '0)); // R6
   end

   assign mask_o = bank_rdata_i[pres_sel];

   AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_rden_o)); // R9
endmodule

// File: rtl/spike_pingpong_ctrl.sv
module spike_pingpong_ctrl #(
   parameter int ROW_BITS = 8,
   parameter int ADDR_W   = 14,
   parameter int CNT_W    = 17,
   parameter int RD_LAT   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                advance_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic                ev_we_i,
   input  logic [ADDR_W-1:0]   ev_addr_i,
   input  logic [ROW_BITS-1:0] ev_mask_i,
   output logic                ready_o,
   output logic                done_o,
   output logic [ROW_BITS-1:0] mask_o,
   output logic [ADDR_W-1:0]   m0_raddr,
   output logic                m0_rden,
   input  logic [ROW_BITS-1:0] m0_rdata,
   output logic [ADDR_W-1:0]   m0_waddr,
   output logic [ROW_BITS-1:0] m0_wdata,
   output logic                m0_wren,
   output logic [ADDR_W-1:0]   m1_raddr,
   output logic                m1_rden,
   input  logic [ROW_BITS-1:0] m1_rdata,
   output logic [ADDR_W-1:0]   m1_waddr,
   output logic [ROW_BITS-1:0] m1_wdata,
   output logic                m1_wren
);
   localparam int SHIFT = $clog2(ROW_BITS);
   localparam int LIM_W = CNT_W - SHIFT;

   if ((1 << SHIFT) != ROW_BITS) begin : g_bad_pow2
      $error("spike_pingpong_ctrl: ROW_BITS must be a power of two");
   end
   if (LIM_W < 1) begin : g_bad_cnt
      $error("spike_pingpong_ctrl: CNT_W too small for ROW_BITS");
   end

   logic [LIM_W-1:0]              rows;
   logic                          swap, rd_en, clr_en;
   logic [ADDR_W-1:0]             rd_addr, clr_addr;
   logic [1:0][ROW_BITS-1:0]      b_rdata, b_wdata;
   logic [1:0][ADDR_W-1:0]        b_raddr, b_waddr;
   logic [1:0]                    b_rden, b_wren;

   assign rows = LIM_W'(count_i >> SHIFT);

   spk_sweep_fsm #(
      .ADDR_W (ADDR_W),
      .LIM_W  (LIM_W),
      .RD_LAT (RD_LAT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .advance_i  (advance_i),
      .rows_i     (rows),
      .ready_o    (ready_o),
      .done_o     (done_o),
      .swap_o     (swap),
      .rd_en_o    (rd_en),
      .rd_addr_o  (rd_addr),
      .clr_en_o   (clr_en),
      .clr_addr_o (clr_addr)
   );

   assign b_rdata = {m1_rdata, m0_rdata};

   spk_bank_route #(
      .ADDR_W   (ADDR_W),
      .ROW_BITS (ROW_BITS)
   ) u_route (
      .clk          (clk),
      .rst_n        (rst_n),
      .swap_i       (swap),
      .rd_en_i      (rd_en),
      .rd_addr_i    (rd_addr),
      .clr_en_i     (clr_en),
      .clr_addr_i   (clr_addr),
      .ev_we_i      (ev_we_i),
      .ev_addr_i    (ev_addr_i),
      .ev_mask_i    (ev_mask_i),
      .bank_rdata_i (b_rdata),
      .bank_raddr_o (b_raddr),
      .bank_rden_o  (b_rden),
      .bank_waddr_o (b_waddr),
      .bank_wdata_o (b_wdata),
      .bank_wren_o  (b_wren),
      .mask_o       (mask_o)
   );

   assign m0_raddr = b_raddr[0];
   assign m0_rden  = b_rden[0];
   assign m0_waddr = b_waddr[0];
   assign m0_wdata = b_wdata[0];
   assign m0_wren  = b_wren[0];
   assign m1_raddr = b_raddr[1];
   assign m1_rden  = b_rden[1];
   assign m1_waddr = b_waddr[1];
   assign m1_wdata = b_wdata[1];
   assign m1_wren  = b_wren[1];

   AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_we_i |-> ((m0_wren && m0_waddr == ev_addr_i && m0_wdata == ev_mask_i && !m0_rden) ||
                   (m1_wren && m1_waddr == ev_addr_i && m1_wdata == ev_mask_i && !m1_rden))); // R2
   AST_READY_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(ready_o && advance_i) || $past(start_i))); // R7
endmodule

// File: tb/test_spike_pingpong_ctrl.sv
module test_spike_pingpong_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, advance_i = 1'b0, ev_we_i = 1'b0;
   logic [16:0] count_i = '0;
   logic [13:0] ev_addr_i = '0;
   logic [7:0]  ev_mask_i = '0;
   logic        ready_o, done_o;
   logic [7:0]  mask_o;
   logic [13:0] m0_raddr, m0_waddr, m1_raddr, m1_waddr;
   logic        m0_rden, m0_wren, m1_rden, m1_wren;
   logic [7:0]  m0_rdata, m0_wdata, m1_rdata, m1_wdata;

   int n_run = 0, n_fail = 0;
   bit fin = 1'b0;

   always #2 clk = ~clk;

   spike_pingpong_ctrl i_spike_pingpong_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .advance_i(advance_i),
      .count_i(count_i), .ev_we_i(ev_we_i), .ev_addr_i(ev_addr_i), .ev_mask_i(ev_mask_i),
      .ready_o(ready_o), .done_o(done_o), .mask_o(mask_o),
      .m0_raddr(m0_raddr), .m0_rden(m0_rden), .m0_rdata(m0_rdata),
      .m0_waddr(m0_waddr), .m0_wdata(m0_wdata), .m0_wren(m0_wren),
      .m1_raddr(m1_raddr), .m1_rden(m1_rden), .m1_rdata(m1_rdata),
      .m1_waddr(m1_waddr), .m1_wdata(m1_wdata), .m1_wren(m1_wren));

   // memory models: 3-stage read pipeline enabled by rden, read-first
   logic [7:0] mem0 [64];
   logic [7:0] mem1 [64];
   logic [7:0] p0a = '0, p0b = '0, p0c = '0, p1a = '0, p1b = '0, p1c = '0;
   assign m0_rdata = p0c;
   assign m1_rdata = p1c;

   always @(posedge clk) begin
      if (m0_wren) mem0[m0_waddr[5:0]] <= m0_wdata;
      if (m0_rden) begin p0a <= mem0[m0_raddr[5:0]]; p0b <= p0a; p0c <= p0b; end
      if (m1_wren) mem1[m1_waddr[5:0]] <= m1_wdata;
      if (m1_rden) begin p1a <= mem1[m1_raddr[5:0]]; p1b <= p1a; p1c <= p1b; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      #1;
      chk(!ready_o && !done_o, "R1 flags in reset", {ready_o, done_o}, 0);
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc(); #1;
      chk(!ready_o && !done_o, "R1 flags after reset", {ready_o, done_o}, 0);
      chk(!m0_wren && !m1_wren && !m0_rden && !m1_rden, "R1 no memory access",
          {m0_wren, m1_wren, m0_rden, m1_rden}, 0);
   endtask

   task automatic t_route();
      logic [7:0] d [5] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hEE};
      for (int r = 0; r < 5; r++) begin
         cyc();
         ev_we_i = 1'b1; ev_addr_i = 14'(r); ev_mask_i = d[r];
         #1;
         chk(m1_wren && m1_waddr == 14'(r) && m1_wdata == d[r] && !m0_wren,
             "R2 event routed to future memory 1", {m1_wren, m0_wren, m1_wdata}, {2'b10, d[r]});
      end
      cyc(); ev_we_i = 1'b0;
      chk(mem1[0] == 8'hA1 && mem1[4] == 8'hEE, "R3 memory 1 is future after reset", mem1[0], 8'hA1);
   endtask

   task automatic t_sweep_first();
      logic [7:0] exp_m [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
      count_i = 17'd32;
      start_i = 1'b1;
      cyc(); start_i = 1'b0;
      for (int r = 0; r < 3; r++) begin
         #1;
         chk(m1_rden && m1_raddr == 14'(r) && !m1_wren && !ready_o, "R4 fill read",
             m1_raddr, r);
         cyc();
      end
      #1;
      chk(ready_o && mask_o == 8'hA1, "R5 ready with row 0 mask", mask_o, 8'hA1);
      for (int r = 0; r < 4; r++) begin
         advance_i = 1'b1;
         if (r == 1) begin ev_we_i = 1'b1; ev_addr_i = 14'd1; ev_mask_i = 8'h5A; end
         if (r == 2) start_i = 1'b1;
         #1;
         chk(ready_o && mask_o == exp_m[r], "R5 mask of lagging row", mask_o, exp_m[r]);
         chk(m1_wren && m1_waddr == 14'(r) && m1_wdata == 8'h00 && m1_rden && m1_raddr == 14'(r + 3),
             "R6 clear and lead read", m1_raddr, r + 3);
         if (r == 1)
            chk(m0_wren && m0_waddr == 14'd1 && m0_wdata == 8'h5A, "R2 event beside clear same row",
                m0_wdata, 8'h5A);
         cyc();
         ev_we_i = 1'b0; start_i = 1'b0;
      end
      advance_i = 1'b0;
      #1;
      chk(done_o && !ready_o, "R7 done after last row", {done_o, ready_o}, 2'b10);
      cyc(); #1;
      chk(!done_o, "R7 done is one cycle", done_o, 0);
      chk(mem1[0] == 0 && mem1[1] == 0 && mem1[2] == 0 && mem1[3] == 0, "R6 swept rows cleared",
          mem1[3], 0);
      chk(mem1[4] == 8'hEE, "R7 row at limit untouched", mem1[4], 8'hEE);
      chk(!ready_o && !m1_rden && !m1_wren, "R3 mid-sweep start ignored, idle", ready_o, 0);
   endtask

   task automatic t_stall();
      cyc();
      ev_we_i = 1'b1; ev_addr_i = 14'd0; ev_mask_i = 8'h11;
      cyc();
      ev_addr_i = 14'd2; ev_mask_i = 8'h33;
      cyc(); ev_we_i = 1'b0;
      chk(mem0[0] == 8'h11 && mem0[1] == 8'h5A, "R3 memory 0 still future", mem0[0], 8'h11);
      count_i = 17'd20;
      start_i = 1'b1;
      cyc(); start_i = 1'b0;
      repeat (3) cyc();
      #1;
      chk(ready_o && mask_o == 8'h11, "R3 swap brought memory 0 to present", mask_o, 8'h11);
      for (int k = 0; k < 3; k++) begin
         cyc(); #1;
         chk(mask_o == 8'h11 && !m0_wren && !m0_rden, "R9 mask held without advance", mask_o, 8'h11);
      end
      advance_i = 1'b1;
      cyc(); advance_i = 1'b0;
      cyc(); #1;
      chk(ready_o && mask_o == 8'h5A, "R9 stalled pipe gives next row", mask_o, 8'h5A);
      advance_i = 1'b1;
      cyc(); advance_i = 1'b0; #1;
      chk(done_o, "R7 floor of count 20 gives two rows", done_o, 1);
      cyc();
      chk(mem0[0] == 0 && mem0[1] == 0 && mem0[2] == 8'h33, "R7 only two rows cleared", mem0[2], 8'h33);
   endtask

   task automatic t_zero();
      count_i = 17'd7;
      start_i = 1'b1;
      cyc(); start_i = 1'b0; #1;
      chk(done_o && !ready_o, "R8 zero rows gives done", {done_o, ready_o}, 2'b10);
      chk(!m0_rden && !m1_rden && !m0_wren && !m1_wren, "R8 no present access",
          {m0_rden, m1_rden, m0_wren, m1_wren}, 0);
      cyc(); #1;
      chk(!done_o, "R8 done one cycle", done_o, 0);
      ev_we_i = 1'b1; ev_addr_i = 14'd9; ev_mask_i = 8'h77;
      #1;
      chk(m0_wren && !m1_wren, "R8 roles swapped despite zero rows", {m0_wren, m1_wren}, 2'b10);
      cyc(); ev_we_i = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin mem0[i] = '0; mem1[i] = '0; end
      t_reset();
      t_route();
      t_sweep_first();
      t_stall();
      t_zero();
      fin = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!fin) begin
         n_run++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule